// File: doc/BRIEF.md
# Two-Car Hall Call Dispatcher

This block coordinates two lift cars that serve a building with two landings, ground and first. It watches the hall call buttons on both landings and the status each car reports: which landing it is at, whether it is travelling, and whether its door is open. It answers each call by sending one car a single-cycle command: travel to ground, travel to first, or open the door. Car-internal buttons, door timing and obstruction handling belong to the cars; the dispatcher only observes their effect through the status pins.

A call is answered by the nearest car that is free. A free car already at the calling landing opens its door without moving. When no free car is there, a free car on the other landing is sent over and opened on arrival. Ties go to the car whose home landing is the calling one: car A is homed on ground, car B on first. A call for a landing that some car is already travelling to is absorbed, and the arriving car serves it. After reset both cars are first sent to ground and then opened once.

Top module: `lift_pair_dispatch`

## Requirements
- R1: While reset is asserted every command output is low. On the first clock edge after reset is released, both cars receive a travel-to-ground pulse in the same cycle.
- R2: After that homing pulse, each car receives exactly one open pulse, issued once the car reports stationary at ground with its door closed. Until then the car is never offered to a hall call.
- R3: A hall call is captured on the rising edge of its button and stays pending until it is served. A button held high produces a single service, however long it is held.
- R4: If a free car is at the calling landing, that car receives an open pulse and no travel command. If both cars are there, the home car for that landing wins (car A for ground, car B for first).
- R5: If no free car is at the calling landing, a free car on the other landing receives a travel pulse toward the calling landing, with the home car preferred. The call stays pending and is served with an open pulse once that car arrives.
- R6: A car reporting moving, with its reported landing (the one it departed) opposite the calling landing, counts as heading there. Such a call dispatches nothing, even if a free car waits at the calling landing. The heading car is opened when it arrives.
- R7: A call from a landing where a car stands with its door already open is discarded without any command, and no command for it appears later.
- R8: A car is free only when it is homed, stationary, has its door closed, and is not receiving a command pulse in the current cycle. A car that is not free receives no dispatch.
- R9: Calls from both landings may be handled in the same cycle, and the ground call is arbitrated first. Each car receives at most one command per cycle, each command is a single-cycle pulse, and a car never receives commands in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_gnd | input | 1 | Ground landing call button (level) |
| hall_fst | input | 1 | First landing call button (level) |
| a_at_fst | input | 1 | Car A landing: 0 ground, 1 first (the departure landing while moving) |
| a_moving | input | 1 | Car A is travelling |
| a_door_open | input | 1 | Car A door is not closed |
| b_at_fst | input | 1 | Car B landing: 0 ground, 1 first (the departure landing while moving) |
| b_moving | input | 1 | Car B is travelling |
| b_door_open | input | 1 | Car B door is not closed |
| a_go_gnd | output | 1 | Pulse: car A travel to ground |
| a_go_fst | output | 1 | Pulse: car A travel to first |
| a_open | output | 1 | Pulse: car A open door |
| b_go_gnd | output | 1 | Pulse: car B travel to ground |
| b_go_fst | output | 1 | Pulse: car B travel to first |
| b_open | output | 1 | Pulse: car B open door |

## Verification
Two decisions can fall in the same cycle: serving a ground call and serving a first-landing call. With both cars idle on ground, the bench raises both buttons on the same clock edge. The ground call must open car A, and the first-landing call must send car B upward in that same cycle, never give car A a second command. The scoreboard expects car A's open and car B's travel in one cycle, followed later by car B's open on arrival, and it flags any extra or reordered pulse.

// File: rtl/lift_pair_pkg.sv
package lift_pair_pkg;
  localparam int NCARS   = 2;
  localparam int NFLOORS = 2;
  localparam int CAR_A   = 0;
  localparam int CAR_B   = 1;
  localparam logic FLR_GND = 1'b0;
  localparam logic FLR_FST = 1'b1;

  typedef struct packed {
    logic go_gnd;
    logic go_fst;
    logic open;
  } car_cmd_t;

  typedef enum logic [1:0] {
    HM_SEND = 2'd0,
    HM_WAIT = 2'd1,
    HM_DONE = 2'd2
  } home_state_t;
endpackage

// File: rtl/hall_call_latch.sv
module hall_call_latch
  import lift_pair_pkg::*;
#(
  parameter int N = NFLOORS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] btn,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] btn_prev;

  for (genvar f = 0; f < N; f++) begin : g_floor
    logic rise;
    assign rise = btn[f] & ~btn_prev[f];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        btn_prev[f] <= 1'b0;
        pend[f]     <= 1'b0;
      end else begin
        btn_prev[f] <= btn[f];
        if (rise)        pend[f] <= 1'b1;
        else if (clr[f]) pend[f] <= 1'b0;
      end
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[f] && !clr[f]) |=> pend[f]); // R3
  end
endmodule

// File: rtl/car_tracker.sv
module car_tracker
  import lift_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     at_fst,
  input  logic     moving,
  input  logic     door_open,
  input  car_cmd_t cmd_now,
  output car_cmd_t home_cmd,
  output logic     homed,
  output logic     avail
);
  home_state_t st;
  logic        busy_pulse;
  logic        parked_gnd;

  assign busy_pulse = |cmd_now;
  assign parked_gnd = !moving && (at_fst == FLR_GND) && !door_open;
  assign homed      = (st == HM_DONE);
  assign avail      = homed && !moving && !door_open && !busy_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= HM_SEND;
      home_cmd <= '0;
    end else begin
      home_cmd <= '0;
      case (st)
        HM_SEND: begin
          home_cmd.go_gnd <= 1'b1;
          st              <= HM_WAIT;
        end
        HM_WAIT: begin
          if (!busy_pulse && parked_gnd) begin
            home_cmd.open <= 1'b1;
            st            <= HM_DONE;
          end
        end
        default: st <= HM_DONE;
      endcase
    end
  end

  AST_HOME_OPEN_AT_GND: assert property (@(posedge clk) disable iff (!rst_n)
    home_cmd.open |-> $past(!moving && at_fst == FLR_GND)); // R2
  AST_HOME_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    homed |=> !home_cmd.go_gnd); // R2
endmodule

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter
  import lift_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NFLOORS-1:0] pend,
  input  logic               at_fst    [NCARS],
  input  logic               moving    [NCARS],
  input  logic               door_open [NCARS],
  input  logic               avail     [NCARS],
  input  car_cmd_t           cmd_now   [NCARS],
  output logic [NFLOORS-1:0] clr,
  output car_cmd_t           cmd_q     [NCARS]
);
  car_cmd_t nxt [NCARS];

  always_comb begin : arb_c
    logic [NCARS-1:0] taken;
    logic heading;
    logic serving;
    logic fl;
    logic ok_h;
    logic ok_o;
    int   h;
    int   o;
    taken = '0;
    clr   = '0;
    for (int c = 0; c < NCARS; c++) nxt[c] = '0;
    for (int f = 0; f < NFLOORS; f++) begin
      fl      = 1'(f);
      h       = (fl == FLR_GND) ? CAR_A : CAR_B;
      o       = (fl == FLR_GND) ? CAR_B : CAR_A;
      heading = 1'b0;
      serving = 1'b0;
      for (int c = 0; c < NCARS; c++) begin
        heading = heading || (moving[c] && at_fst[c] != fl)
                          || ((fl == FLR_GND) ? cmd_now[c].go_gnd : cmd_now[c].go_fst);
        serving = serving || (!moving[c] && at_fst[c] == fl
                              && (door_open[c] || cmd_now[c].open));
      end
      ok_h = avail[h] && !taken[h];
      ok_o = avail[o] && !taken[o];
      if (pend[f]) begin
        if (serving) begin
          clr[f] = 1'b1;
        end else if (heading) begin
          clr[f] = 1'b0;
        end else if (ok_h && at_fst[h] == fl) begin
          nxt[h].open = 1'b1;
          taken[h]    = 1'b1;
          clr[f]      = 1'b1;
        end else if (ok_o && at_fst[o] == fl) begin
          nxt[o].open = 1'b1;
          taken[o]    = 1'b1;
          clr[f]      = 1'b1;
        end else if (ok_h) begin
          if (fl == FLR_GND) nxt[h].go_gnd = 1'b1;
          else               nxt[h].go_fst = 1'b1;
          taken[h] = 1'b1;
        end else if (ok_o) begin
          if (fl == FLR_GND) nxt[o].go_gnd = 1'b1;
          else               nxt[o].go_fst = 1'b1;
          taken[o] = 1'b1;
        end
      end
    end
  end

  for (genvar c = 0; c < NCARS; c++) begin : g_car
    always_ff @(posedge clk) begin
      if (!rst_n) cmd_q[c] <= '0;
      else        cmd_q[c] <= nxt[c];
    end

    AST_DISPATCH_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_q[c]) |-> $past(!moving[c] && !door_open[c])); // R8
    AST_ONE_CMD_PER_CAR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q[c])); // R9
  end
endmodule

// File: rtl/lift_pair_dispatch.sv
module lift_pair_dispatch
  import lift_pair_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hall_gnd,
  input  logic hall_fst,
  input  logic a_at_fst,
  input  logic a_moving,
  input  logic a_door_open,
  input  logic b_at_fst,
  input  logic b_moving,
  input  logic b_door_open,
  output logic a_go_gnd,
  output logic a_go_fst,
  output logic a_open,
  output logic b_go_gnd,
  output logic b_go_fst,
  output logic b_open
);
  logic               flr   [NCARS];
  logic               mov   [NCARS];
  logic               door  [NCARS];
  logic               avail [NCARS];
  logic               homed [NCARS];
  car_cmd_t           home_cmd [NCARS];
  car_cmd_t           arb_cmd  [NCARS];
  car_cmd_t           cmd_out  [NCARS];
  logic [NFLOORS-1:0] pend;
  logic [NFLOORS-1:0] clr;

  assign flr[CAR_A]  = a_at_fst;
  assign flr[CAR_B]  = b_at_fst;
  assign mov[CAR_A]  = a_moving;
  assign mov[CAR_B]  = b_moving;
  assign door[CAR_A] = a_door_open;
  assign door[CAR_B] = b_door_open;

  hall_call_latch #(.N(NFLOORS)) u_calls (
    .clk   (clk),
    .rst_n (rst_n),
    .btn   ({hall_fst, hall_gnd}),
    .clr   (clr),
    .pend  (pend)
  );

  for (genvar c = 0; c < NCARS; c++) begin : g_trk
    car_tracker u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .at_fst    (flr[c]),
      .moving    (mov[c]),
      .door_open (door[c]),
      .cmd_now   (cmd_out[c]),
      .home_cmd  (home_cmd[c]),
      .homed     (homed[c]),
      .avail     (avail[c])
    );
    assign cmd_out[c] = home_cmd[c] | arb_cmd[c];

    AST_ARB_AFTER_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (|arb_cmd[c]) |-> homed[c]); // R2
  end

  dispatch_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .at_fst    (flr),
    .moving    (mov),
    .door_open (door),
    .avail     (avail),
    .cmd_now   (cmd_out),
    .clr       (clr),
    .cmd_q     (arb_cmd)
  );

  assign a_go_gnd = cmd_out[CAR_A].go_gnd;
  assign a_go_fst = cmd_out[CAR_A].go_fst;
  assign a_open   = cmd_out[CAR_A].open;
  assign b_go_gnd = cmd_out[CAR_B].go_gnd;
  assign b_go_fst = cmd_out[CAR_B].go_fst;
  assign b_open   = cmd_out[CAR_B].open;

  AST_PULSE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_go_gnd || a_go_fst || a_open) |=> !(a_go_gnd || a_go_fst || a_open)); // R9
  AST_PULSE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_go_gnd || b_go_fst || b_open) |=> !(b_go_gnd || b_go_fst || b_open)); // R9
  AST_ONEHOT_A: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_go_gnd, a_go_fst, a_open})); // R9
  AST_ONEHOT_B: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({b_go_gnd, b_go_fst, b_open})); // R9
endmodule

// File: tb/lift_pair_dispatch_bench.sv
module lift_pair_dispatch_bench;
  localparam int TRAVEL = 6;
  localparam int DWELL  = 6;
  localparam int WDOG   = 20000;

  typedef struct {
    int    code;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hall_gnd = 1'b0;
  logic hall_fst = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] m_fst, m_mov, m_door, m_tgt;
  logic [1:0] force_door = 2'b00;
  logic [1:0] cab_req = 2'b00;
  logic [1:0] cab_tgt = 2'b00;
  logic [1:0] cab_ack;
  int         m_cnt [2];
  int         m_dcnt [2];

  logic a_go_gnd, a_go_fst, a_open, b_go_gnd, b_go_fst, b_open;
  logic [1:0] go_g, go_f, op;
  assign go_g = {b_go_gnd, a_go_gnd};
  assign go_f = {b_go_fst, a_go_fst};
  assign op   = {b_open, a_open};

  lift_pair_dispatch u_lift_pair_dispatch (
    .clk(clk), .rst_n(rst_n), .hall_gnd(hall_gnd), .hall_fst(hall_fst),
    .a_at_fst(m_fst[0]), .a_moving(m_mov[0]), .a_door_open(m_door[0] | force_door[0]),
    .b_at_fst(m_fst[1]), .b_moving(m_mov[1]), .b_door_open(m_door[1] | force_door[1]),
    .a_go_gnd(a_go_gnd), .a_go_fst(a_go_fst), .a_open(a_open),
    .b_go_gnd(b_go_gnd), .b_go_fst(b_go_fst), .b_open(b_open)
  );

  // Car models: car A starts on first, car B on ground.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fst <= 2'b01; m_mov <= 2'b00; m_door <= 2'b00; m_tgt <= 2'b00; cab_ack <= 2'b00;
      for (int i = 0; i < 2; i++) begin m_cnt[i] <= 0; m_dcnt[i] <= 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (m_mov[i]) begin
          if (m_cnt[i] == 1) begin m_mov[i] <= 1'b0; m_fst[i] <= m_tgt[i]; end
          else m_cnt[i] <= m_cnt[i] - 1;
        end else if (!m_door[i] && !force_door[i]) begin
          if (go_f[i] && !m_fst[i]) begin
            m_mov[i] <= 1'b1; m_tgt[i] <= 1'b1; m_cnt[i] <= TRAVEL;
          end else if (go_g[i] && m_fst[i]) begin
            m_mov[i] <= 1'b1; m_tgt[i] <= 1'b0; m_cnt[i] <= TRAVEL;
          end else if (cab_req[i] != cab_ack[i]) begin
            cab_ack[i] <= cab_req[i];
            if (cab_tgt[i] != m_fst[i]) begin
              m_mov[i] <= 1'b1; m_tgt[i] <= cab_tgt[i]; m_cnt[i] <= TRAVEL;
            end
          end
        end
        if (op[i]) begin m_door[i] <= 1'b1; m_dcnt[i] <= DWELL; end
        else if (m_door[i]) begin
          if (m_dcnt[i] == 1) m_door[i] <= 1'b0;
          else m_dcnt[i] <= m_dcnt[i] - 1;
        end
      end
    end
  end

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic done     = 1'b0;

  function automatic string cmd_name(int code);
    string car;
    car = (code / 3 == 0) ? "A" : "B";
    case (code % 3)
      0: return {car, ".go_gnd"};
      1: return {car, ".go_fst"};
      default: return {car, ".open"};
    endcase
  endfunction

  task automatic expect_cmd(int car, int cmd, string tag);
    exp_t e;
    e.code = car * 3 + cmd;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: car A pulses before car B within a cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 3; k++) begin
          logic hit;
          hit = (k == 0) ? go_g[c] : (k == 1) ? go_f[c] : op[c];
          if (hit) begin
            n_checks++;
            if (exp_q.size() == 0) begin
              n_fails++;
              $display("FAIL unexpected command: actual %s expected none", cmd_name(c * 3 + k));
            end else begin
              exp_t e;
              e = exp_q.pop_front();
              if (e.code != c * 3 + k) begin
                n_fails++;
                $display("FAIL %s: actual %s expected %s", e.tag, cmd_name(c * 3 + k), cmd_name(e.code));
              end
            end
          end
        end
      end
    end
  end

  task automatic check_drained(string tag);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL %s: actual %0d outstanding commands expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic wait_quiet();
    repeat (3) @(negedge clk);
    while (exp_q.size() != 0 || m_mov != 2'b00 || m_door != 2'b00) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic press(bit gnd, bit fst, int hold);
    @(negedge clk);
    hall_gnd = gnd; hall_fst = fst;
    repeat (hold) @(negedge clk);
    hall_gnd = 1'b0; hall_fst = 1'b0;
  endtask

  task automatic cab(int car, bit tgt);
    @(negedge clk);
    cab_tgt[car] = tgt;
    cab_req[car] = ~cab_req[car];
    repeat (2) @(negedge clk);
    while (m_mov[car] || cab_req[car] != cab_ack[car]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_checks++; // R1: outputs low during reset
    if ({go_g, go_f, op} != 6'b0) begin
      n_fails++;
      $display("FAIL R1: actual %b expected 000000", {go_g, go_f, op});
    end
    expect_cmd(0, 0, "R1"); expect_cmd(1, 0, "R1");
    expect_cmd(1, 2, "R2"); expect_cmd(0, 2, "R2");
    rst_n = 1'b1;
    wait_quiet();
    check_drained("R2");

    // R4: both on ground, ground call opens home car A
    expect_cmd(0, 2, "R4");
    press(1, 0, 2);
    wait_quiet();
    check_drained("R4");

    // R5: first call, both on ground, home car B travels then opens
    expect_cmd(1, 1, "R5"); expect_cmd(1, 2, "R5");
    press(0, 1, 2);
    wait_quiet();
    check_drained("R5");

    // R4: B at first, A at ground
    expect_cmd(1, 2, "R4");
    press(0, 1, 2);
    wait_quiet();
    expect_cmd(0, 2, "R4");
    press(1, 0, 2);
    wait_quiet();
    check_drained("R4");

    // R5: both on first, ground call goes to home car A
    cab(0, 1'b1);
    expect_cmd(0, 0, "R5"); expect_cmd(0, 2, "R5");
    press(1, 0, 2);
    wait_quiet();
    check_drained("R5");

    // R8: both on first, A door held open, ground call falls to B
    cab(0, 1'b1);
    force_door[0] = 1'b1;
    expect_cmd(1, 0, "R8"); expect_cmd(1, 2, "R8");
    press(1, 0, 2);
    wait_quiet();
    force_door[0] = 1'b0;
    repeat (4) @(negedge clk);
    check_drained("R8");

    // R6: A travels to ground by cab, ground call while in flight; B idle on ground stays put
    @(negedge clk);
    cab_tgt[0] = 1'b0;
    cab_req[0] = ~cab_req[0];
    repeat (3) @(negedge clk);
    expect_cmd(0, 2, "R6");
    press(1, 0, 2);
    wait_quiet();
    check_drained("R6");

    // R7: A door held open on ground, ground call absorbed silently
    force_door[0] = 1'b1;
    press(1, 0, 2);
    repeat (10) @(negedge clk);
    force_door[0] = 1'b0;
    repeat (20) @(negedge clk);
    check_drained("R7");

    // R3: button held high for 30 cycles gives a single service
    expect_cmd(0, 2, "R3");
    press(1, 0, 30);
    wait_quiet();
    check_drained("R3");

    // R9: both calls in one cycle, A opens on ground while B goes up
    expect_cmd(0, 2, "R9"); expect_cmd(1, 1, "R9"); expect_cmd(1, 2, "R9");
    press(1, 1, 2);
    wait_quiet();
    check_drained("R9");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule